// File: doc/BRIEF.md
# Message Receive Engine with Automatic Acknowledge

This block sits between a core's pipeline and two on-chip message networks. Messages arrive from the request network and wait in one finite receive queue. All senders share that queue, and entries are kept in the order they arrived. The pipeline issues a receive by holding `recv_req_i` high. The block stalls that receive until a message is at the head of the queue. It then hands the message to the pipeline: a size code and up to four payload words, marked by a one-cycle valid strobe.

Removing a message from the queue makes the block queue an acknowledge for that message's sender. The acknowledge goes out on a separate reply port. The sender address of the most recent message is also kept. A later resume instruction uses it to send an explicit reply that carries one data word. Both acknowledges and resume replies go out only on the reply port. The block has no output toward the request network, so request traffic and reply traffic stay on separate networks.

Top module: `msg_rx_engine`

## Requirements
- R1: After reset, `net_ready_o` is 1, `recv_valid_o` is 0, `recv_stall_o` is 0, `rep_valid_o` is 0 and `resume_ready_o` is 0.
- R2: Messages from any mix of sources are delivered to the pipeline in the exact order the request network handed them over.
- R3: `net_ready_o` is 0 exactly when the queue holds DEPTH messages. A message is taken only in a cycle where `net_valid_i` and `net_ready_o` are both 1, and no taken message is ever lost.
- R4: A receive stalls while the queue is empty: `recv_stall_o` is 1 and `recv_valid_o` is 0. A message taken at a clock edge can complete a waiting receive in the cycle that follows that edge.
- R5: When a receive completes, `recv_valid_o` is 1 for that cycle and `recv_stall_o` is 0. `recv_size_o` holds the size code, which is the word count minus one (0 to 3). `recv_data_o` holds word i in bits [32*i+31:32*i], and any word with i greater than the size code reads as zero.
- R6: In the cycle after a receive completes, the reply port shows an acknowledge: `rep_kind_o`=0, `rep_dst_o` set to the sender of that message, and `rep_data_o`=0. The acknowledge stays on the port until `rep_ready_i` is 1.
- R7: Each completed receive records its sender as the resume target. Before the first receive completes, `resume_ready_o` stays 0 and a resume request puts nothing on the reply port.
- R8: A resume request is sent as `rep_kind_o`=1, with `rep_dst_o` set to the recorded sender and `rep_data_o` set to `resume_data_i`. It is accepted when `resume_ready_o` and `resume_valid_i` are both 1.
- R9: When an acknowledge is pending, it takes the reply port ahead of any resume request, and `resume_ready_o` is 0.
- R10: A receive also stalls while an earlier acknowledge is still waiting and `rep_ready_i` is 0. No acknowledge is ever overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| net_valid_i | input | 1 | Request network offers a message |
| net_ready_o | output | 1 | Queue can take a message |
| net_src_i | input | SRC_W | Sender core address of the offered message |
| net_size_i | input | 2 | Word count minus one |
| net_data_i | input | WORDS*DATA_W | Payload words, word 0 in the low bits |
| recv_req_i | input | 1 | Pipeline receive request, held until it completes |
| recv_stall_o | output | 1 | Receive requested but cannot complete this cycle |
| recv_valid_o | output | 1 | Receive completes this cycle |
| recv_size_o | output | 2 | Size code of the delivered message |
| recv_data_o | output | WORDS*DATA_W | Delivered payload, unused words zero |
| resume_valid_i | input | 1 | Pipeline resume request |
| resume_data_i | input | DATA_W | Data word carried by the resume reply |
| resume_ready_o | output | 1 | Resume reply is sent this cycle if requested |
| rep_valid_o | output | 1 | Reply port carries a message |
| rep_ready_i | input | 1 | Reply network accepts the message |
| rep_kind_o | output | 1 | 0 = acknowledge, 1 = resume reply |
| rep_dst_o | output | SRC_W | Destination core of the reply |
| rep_data_o | output | DATA_W | Reply data, zero for an acknowledge |

## Verification
The assertions are checked on every cycle. They cover the following: the queue is never pushed when full and never popped when empty; an empty queue always stalls a receive; an acknowledge appears on the cycle after each receive, addressed to that message's sender, and holds steady under back-pressure; a pending acknowledge is never overwritten by a new receive; and a resume reply is never accepted while an acknowledge waits. Some behaviours can only be shown by the bench's scenarios, because they depend on sequences that run over many cycles: source-independent arrival order across a full queue, zeroing of unused payload words for every size code, the rule that no resume goes out before the first receive, and the resume target moving to each new sender.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  typedef enum logic {
    REP_ACK    = 1'b0,
    REP_RESUME = 1'b1
  } rep_kind_e;

  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/msg_rx_fifo.sv
module msg_rx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/msg_rx_mask.sv
module msg_rx_mask #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [SIZE_W-1:0]       size_i,
  input  logic [WORDS*DATA_W-1:0] data_i,
  output logic [WORDS*DATA_W-1:0] data_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [SIZE_W-1:0] IDX = SIZE_W'(w);
    assign data_o[w*DATA_W +: DATA_W] =
      (IDX <= size_i) ? data_i[w*DATA_W +: DATA_W] : '0;
  end
endmodule

// File: rtl/msg_rx_reply.sv
module msg_rx_reply
  import msg_rx_pkg::*;
#(
  parameter int unsigned SRC_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deq_i,
  input  logic [SRC_W-1:0]  deq_src_i,
  output logic              slot_free_o,
  input  logic              resume_valid_i,
  input  logic [DATA_W-1:0] resume_data_i,
  output logic              resume_ready_o,
  output logic              rep_valid_o,
  input  logic              rep_ready_i,
  output rep_kind_e         rep_kind_o,
  output logic [SRC_W-1:0]  rep_dst_o,
  output logic [DATA_W-1:0] rep_data_o
);
  logic             ack_pend_q, last_vld_q;
  logic [SRC_W-1:0] ack_dst_q, last_src_q;

  // one acknowledge slot; it is free if empty or draining now
  assign slot_free_o    = !ack_pend_q || rep_ready_i;
  assign resume_ready_o = last_vld_q && !ack_pend_q && rep_ready_i;
  assign rep_valid_o    = ack_pend_q || (resume_valid_i && last_vld_q);
  assign rep_kind_o     = ack_pend_q ? REP_ACK : REP_RESUME;
  assign rep_dst_o      = ack_pend_q ? ack_dst_q : last_src_q;
  assign rep_data_o     = ack_pend_q ? '0 : resume_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_pend_q <= 1'b0;
      ack_dst_q  <= '0;
      last_src_q <= '0;
      last_vld_q <= 1'b0;
    end else if (deq_i) begin
      ack_pend_q <= 1'b1;
      ack_dst_q  <= deq_src_i;
      last_src_q <= deq_src_i;
      last_vld_q <= 1'b1;
    end else if (rep_ready_i) begin
      ack_pend_q <= 1'b0;
    end
  end

  // R6
  ack_follows_recv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |=> rep_valid_o && rep_kind_o == REP_ACK && rep_dst_o == $past(deq_src_i));
  // R6
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o && rep_kind_o == REP_ACK && !rep_ready_i
      |=> rep_valid_o && rep_kind_o == REP_ACK && $stable(rep_dst_o));
  // R10
  ack_no_clobber_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> !(rep_valid_o && rep_kind_o == REP_ACK && !rep_ready_i));
  // R9
  ack_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pend_q |-> !resume_ready_o);
endmodule

// File: rtl/msg_rx_engine.sv
module msg_rx_engine
  import msg_rx_pkg::*;
#(
  parameter int unsigned SRC_W  = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    net_valid_i,
  output logic                    net_ready_o,
  input  logic [SRC_W-1:0]        net_src_i,
  input  logic [SIZE_W-1:0]       net_size_i,
  input  logic [WORDS*DATA_W-1:0] net_data_i,
  input  logic                    recv_req_i,
  output logic                    recv_stall_o,
  output logic                    recv_valid_o,
  output logic [SIZE_W-1:0]       recv_size_o,
  output logic [WORDS*DATA_W-1:0] recv_data_o,
  input  logic                    resume_valid_i,
  input  logic [DATA_W-1:0]       resume_data_i,
  output logic                    resume_ready_o,
  output logic                    rep_valid_o,
  input  logic                    rep_ready_i,
  output logic                    rep_kind_o,
  output logic [SRC_W-1:0]        rep_dst_o,
  output logic [DATA_W-1:0]       rep_data_o
);
  localparam int unsigned PAY_W   = WORDS * DATA_W;
  localparam int unsigned ENTRY_W = SRC_W + SIZE_W + PAY_W;

  logic               q_empty, q_full, q_push, q_pop, slot_free;
  logic [ENTRY_W-1:0] q_head;
  logic [SRC_W-1:0]   head_src;
  logic [SIZE_W-1:0]  head_size;
  logic [PAY_W-1:0]   head_data;
  rep_kind_e          kind;

  assign net_ready_o = !q_full;
  assign q_push      = net_valid_i && !q_full;
  assign q_pop       = recv_req_i && !q_empty && slot_free;
  assign {head_src, head_size, head_data} = q_head;

  assign recv_valid_o = q_pop;
  assign recv_stall_o = recv_req_i && !q_pop;
  assign recv_size_o  = head_size;
  assign rep_kind_o   = logic'(kind);

  msg_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (q_push),
    .push_data_i ({net_src_i, net_size_i, net_data_i}),
    .pop_i       (q_pop),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .full_o      (q_full)
  );

  msg_rx_mask #(.DATA_W(DATA_W), .WORDS(WORDS), .SIZE_W(SIZE_W)) u_mask (
    .size_i (head_size),
    .data_i (head_data),
    .data_o (recv_data_o)
  );

  msg_rx_reply #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_reply (
    .clk_i, .rst_ni,
    .deq_i          (q_pop),
    .deq_src_i      (head_src),
    .slot_free_o    (slot_free),
    .resume_valid_i,
    .resume_data_i,
    .resume_ready_o,
    .rep_valid_o,
    .rep_ready_i,
    .rep_kind_o     (kind),
    .rep_dst_o,
    .rep_data_o
  );

  // R4
  empty_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recv_req_i && q_empty |-> recv_stall_o && !recv_valid_o);
endmodule

// File: tb/tb_msg_rx_engine.sv
`timescale 1ns/1ps
module tb_msg_rx_engine;
  localparam int SW = 6, DW = 32, NW = 4, DEP = 4;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic            net_valid, net_ready, recv_req, recv_stall, recv_valid;
  logic [SW-1:0]   net_src, rep_dst;
  logic [1:0]      net_size, recv_size;
  logic [NW*DW-1:0] net_data, recv_data;
  logic            resume_valid, resume_ready, rep_valid, rep_ready, rep_kind;
  logic [DW-1:0]   resume_data, rep_data;

  msg_rx_engine #(.SRC_W(SW), .DATA_W(DW), .WORDS(NW), .DEPTH(DEP)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .net_valid_i(net_valid), .net_ready_o(net_ready), .net_src_i(net_src),
    .net_size_i(net_size), .net_data_i(net_data),
    .recv_req_i(recv_req), .recv_stall_o(recv_stall), .recv_valid_o(recv_valid),
    .recv_size_o(recv_size), .recv_data_o(recv_data),
    .resume_valid_i(resume_valid), .resume_data_i(resume_data),
    .resume_ready_o(resume_ready),
    .rep_valid_o(rep_valid), .rep_ready_i(rep_ready), .rep_kind_o(rep_kind),
    .rep_dst_o(rep_dst), .rep_data_o(rep_data)
  );

  typedef struct { logic [SW-1:0] src; logic [1:0] sz; logic [NW*DW-1:0] d; } msg_t;
  msg_t q[$];
  bit m_ack = 0, m_lvld = 0;
  logic [SW-1:0] m_ackdst = '0, m_last = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [NW*DW-1:0] act, input logic [NW*DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NW*DW-1:0] masked(input msg_t m);
    logic [NW*DW-1:0] r = '0;
    for (int i = 0; i < NW; i++)
      if (i <= int'(m.sz)) r[i*DW +: DW] = m.d[i*DW +: DW];
    return r;
  endfunction

  function automatic logic [NW*DW-1:0] pay(input int k);
    return {DW'(32'hD000_0000 + k*4 + 3), DW'(32'hC000_0000 + k*4 + 2),
            DW'(32'hB000_0000 + k*4 + 1), DW'(32'hA000_0000 + k*4)};
  endfunction

  // one cycle: drive, compare against model, clock, update model
  task automatic step(input bit nv, input logic [SW-1:0] s, input logic [1:0] sz,
                      input logic [NW*DW-1:0] d, input bit rr, input bit rv,
                      input logic [DW-1:0] rd, input bit rp);
    bit e_full, e_empty, e_deq, e_rv, e_rr;
    msg_t h, nm;
    net_valid = nv; net_src = s; net_size = sz; net_data = d;
    recv_req = rr; resume_valid = rv; resume_data = rd; rep_ready = rp;
    #1;
    e_full  = (q.size() == DEP);
    e_empty = (q.size() == 0);
    e_deq   = rr && !e_empty && (!m_ack || rp);
    e_rv    = m_ack || (rv && m_lvld);
    e_rr    = m_lvld && !m_ack && rp;
    chk("R3", "net_ready", net_ready, !e_full);
    chk("R4", "recv_stall", recv_stall, rr && !e_deq);
    chk("R10", "recv_valid", recv_valid, e_deq);
    chk("R7", "resume_ready", resume_ready, e_rr);
    chk("R6", "rep_valid", rep_valid, e_rv);
    if (e_deq) begin
      h = q[0];
      chk("R5", "recv_size", recv_size, h.sz);
      chk("R2", "recv_data", recv_data, masked(h));
    end
    if (e_rv) begin
      chk("R9", "rep_kind", rep_kind, !m_ack);
      chk("R8", "rep_dst", rep_dst, m_ack ? m_ackdst : m_last);
      chk("R8", "rep_data", rep_data, m_ack ? '0 : rd);
    end
    @(posedge clk);
    if (e_deq) begin
      h = q.pop_front();
      m_ack = 1; m_ackdst = h.src; m_last = h.src; m_lvld = 1;
    end else if (rp) m_ack = 0;
    if (nv && !e_full) begin
      nm.src = s; nm.sz = sz; nm.d = d;
      q.push_back(nm);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit rp);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, 0, '0, rp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int k;
    net_valid = 0; net_src = '0; net_size = '0; net_data = '0;
    recv_req = 0; resume_valid = 0; resume_data = '0; rep_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "net_ready", net_ready, 1);
    chk("R1", "recv_valid", recv_valid, 0);
    chk("R1", "recv_stall", recv_stall, 0);
    chk("R1", "rep_valid", rep_valid, 0);
    chk("R1", "resume_ready", resume_ready, 0);
    @(negedge clk);

    // R7: resume before any receive sends nothing
    step(0, '0, '0, '0, 0, 1, 32'h1234, 1);
    step(0, '0, '0, '0, 0, 1, 32'h1234, 1);

    // R4: receive waits on empty queue, then a message arrives
    idle(0, 1);
    step(0, '0, '0, '0, 1, 0, '0, 1);
    step(0, '0, '0, '0, 1, 0, '0, 1);
    step(1, 6'd9, 2'd1, pay(0), 1, 0, '0, 1);
    step(0, '0, '0, '0, 1, 0, '0, 1);
    idle(2, 1);

    // R3/R2: fill from distinct sources, keep offering while full
    k = 1;
    for (int c = 0; c < 8; c++) begin
      bit rdy = (q.size() < DEP);
      step(1, SW'(k * 5), 2'(k), pay(k), 0, 0, '0, 1);
      if (rdy) k++;
    end
    // R10: drain with reply port blocked, then released
    step(0, '0, '0, '0, 1, 0, '0, 0);
    step(0, '0, '0, '0, 1, 0, '0, 0);
    step(0, '0, '0, '0, 1, 0, '0, 0);
    // R9: resume competes with pending acknowledge
    step(0, '0, '0, '0, 0, 1, 32'hCAFE, 1);
    step(0, '0, '0, '0, 0, 1, 32'hCAFE, 1);
    // R8: resume to recorded sender
    step(0, '0, '0, '0, 0, 1, 32'hBEEF, 1);
    for (int c = 0; c < 10; c++) step(0, '0, '0, '0, 1, c[0], 32'h55 + c, 1);
    idle(2, 1);

    // mixed traffic; R5 exercises all size codes
    for (int c = 0; c < 3000; c++) begin
      step($urandom_range(0, 2) != 0, SW'($urandom), 2'($urandom), pay(100 + c),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, DW'($urandom),
           $urandom_range(0, 3) != 0);
    end
    for (int c = 0; c < 12; c++) step(0, '0, '0, '0, 1, 0, '0, 1);
    idle(3, 1);
    finish_run();
  end
endmodule